// File: doc/BRIEF.md
# DMA Status Word Tracker

This block keeps the status word of a DMA engine that works through a chain of descriptors. The datapath sends it single-cycle event pulses for four cases: a stream error, a transfer cut short by an end-of-packet from the stream source, a finished descriptor, and a finished chain. The block holds each event as a sticky flag. Software clears a flag by writing a one to its bit.

The block also produces an activity flag. It takes three inputs for this: the engine's run control bit, the stop-on-error control bit, and an idle indication from the engine. The flag rises on the cycle after run goes high. It falls in one of two cases. The first is when the engine is idle and run is low. The second is when an error has been seen with stop-on-error set and the descriptor in flight then completes.

Software reaches the word through one 32-bit register with a read strobe and a write strobe. Read data is registered and holds between reads. The port is plain strobe/data with no handshake, because every access completes in one cycle.

Top module: `dma_stat_tracker`

## Requirements
- R1: Bit 0 (stream error) is set by a pulse on `ev_stream_err` and cleared by a write with `reg_wdata[0]`=1.
- R2: When `STREAM_TO_MEM`=1, bit 1 (end-of-packet stop) is set by `ev_eop` and cleared by a write with `reg_wdata[1]`=1.
- R3: When `STREAM_TO_MEM`=0, bit 1 stays 0 whatever `ev_eop` does.
- R4: Bit 2 (descriptor done) is set by `ev_desc_done` and stays set until a write with `reg_wdata[2]`=1.
- R5: Bit 3 (chain done) is set by `ev_chain_done` and cleared by a write with `reg_wdata[3]`=1.
- R6: Bit 4 (busy) becomes 1 on the clock edge that follows the first cycle in which `ctl_run` is 1 after having been 0. Writes have no effect on bit 4.
- R7: Busy falls on the edge after a cycle in which it is 1, `eng_idle` is 1 and `ctl_run` is 0.
- R8: Suppose `ev_stream_err` arrives while busy and `ctl_stop_on_err` are both 1. Busy then falls on the edge after the next `ev_desc_done`, and not before, while `ctl_run` stays 1.
- R9: Bits 31:5 always read 0, and writes to them have no effect.
- R10: If a set event and a write-one-to-clear hit the same flag in one cycle, the flag ends up set. Writing 0 to a flag bit leaves it unchanged.
- R11: Reset clears all flags and busy. `reg_rdata` takes the word as it stood in the cycle `reg_rd` was 1, one edge later, and holds that value while `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_stream_err | input | 1 | Stream error event pulse |
| ev_eop | input | 1 | End-of-packet termination event pulse |
| ev_desc_done | input | 1 | Descriptor completed event pulse |
| ev_chain_done | input | 1 | Chain completed event pulse |
| ctl_run | input | 1 | Engine run control bit |
| ctl_stop_on_err | input | 1 | Stop-on-error control bit |
| eng_idle | input | 1 | Engine has no descriptor in progress |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data; a one clears the matching flag |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |

## Verification
Each result has a fixed delay. An event pulse or a write changes a flag at the edge that ends its cycle. A read strobe loads `reg_rdata` at the same edge, using the value from before that edge. Busy rises one edge after the run edge and falls one edge after its clearing condition. So a read made in the next cycle shows the new state. The bench drives all inputs on the falling edge and samples `reg_rdata` on the following falling edge. Every check therefore lands exactly one register stage after its strobe. For the one-cycle rise of busy, a read is issued in the same cycle that run is raised, and the bench expects busy to read 0 there and 1 on the next read.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned BIT_ERR   = 0;
  localparam int unsigned BIT_EOP   = 1;
  localparam int unsigned BIT_DESC  = 2;
  localparam int unsigned BIT_CHAIN = 3;
  localparam int unsigned BIT_BUSY  = NUM_FLAGS;
  localparam int unsigned USED_W    = NUM_FLAGS + 1;
endpackage

// File: rtl/dma_stat_flags.sv
module dma_stat_flags #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flag_q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (set_vec[i])
        flag_q[i] <= 1'b1;          // set beats clear
      else if (clr_vec[i])
        flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_stat_busy.sv
module dma_stat_busy (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stop_on_err,
  input  logic eng_idle,
  input  logic ev_err,
  input  logic ev_done,
  output logic busy_q
);
  logic run_d;
  logic err_pend;
  logic run_rise, err_hit, stop_now, fin_now;

  always_comb begin
    run_rise = run & ~run_d;
    err_hit  = stop_on_err & ev_err;
    stop_now = (err_pend | err_hit) & ev_done;
    fin_now  = eng_idle & ~run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_d    <= 1'b0;
      busy_q   <= 1'b0;
      err_pend <= 1'b0;
    end else begin
      run_d <= run;
      if (run_rise) begin
        busy_q   <= 1'b1;
        err_pend <= 1'b0;
      end else if (busy_q && (fin_now || stop_now)) begin
        busy_q   <= 1'b0;
        err_pend <= 1'b0;
      end else if (busy_q && err_hit) begin
        err_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_stat_rdport.sv
module dma_stat_rdport #(
  parameter int unsigned DW = 32,
  parameter int unsigned UW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [UW-1:0] word,
  output logic [DW-1:0] rdata
);
  localparam int unsigned PAD_W = DW - UW;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd)
      rdata <= {{PAD_W{1'b0}}, word};
  end
endmodule

// File: rtl/dma_stat_tracker.sv
module dma_stat_tracker
  import dma_stat_pkg::*;
#(
  parameter bit STREAM_TO_MEM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_stream_err,
  input  logic             ev_eop,
  input  logic             ev_desc_done,
  input  logic             ev_chain_done,
  input  logic             ctl_run,
  input  logic             ctl_stop_on_err,
  input  logic             eng_idle,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata
);
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_q;
  logic                 busy_q;
  logic [USED_W-1:0]    word;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_ERR]   = ev_stream_err;
    set_vec[BIT_EOP]   = ev_eop & STREAM_TO_MEM;
    set_vec[BIT_DESC]  = ev_desc_done;
    set_vec[BIT_CHAIN] = ev_chain_done;
    clr_vec = reg_wr ? reg_wdata[NUM_FLAGS-1:0] : '0;
    word    = {busy_q, flag_q};
  end

  dma_stat_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag_q(flag_q)
  );

  dma_stat_busy u_busy (
    .clk(clk), .rst_n(rst_n), .run(ctl_run), .stop_on_err(ctl_stop_on_err),
    .eng_idle(eng_idle), .ev_err(ev_stream_err), .ev_done(ev_desc_done), .busy_q(busy_q)
  );

  dma_stat_rdport #(.DW(REG_W), .UW(USED_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .word(word), .rdata(reg_rdata)
  );
endmodule

// File: rtl/dma_stat_tracker_chk.sv
module dma_stat_tracker_chk #(
  parameter bit STREAM_TO_MEM = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_stream_err,
  input logic        ev_eop,
  input logic        ev_desc_done,
  input logic        ctl_run,
  input logic        eng_idle,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        reg_rd,
  input logic [31:0] reg_rdata,
  input logic [3:0]  flags,
  input logic        busy
);
  p_err_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[0] && !ev_stream_err) |=> !flags[0]);
  p_eop_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eop && STREAM_TO_MEM) |=> flags[1]);
  p_eop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!STREAM_TO_MEM && !flags[1]) |=> !flags[1]);
  p_desc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_desc_done |=> flags[2]);
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_run) |=> busy);
  p_busy_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_idle && !ctl_run) |=> !busy);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_run && !ev_desc_done) |=> busy);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:5] == 27'd0);
  p_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rdata == {27'd0, $past(busy), $past(flags)});
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind dma_stat_tracker dma_stat_tracker_chk #(.STREAM_TO_MEM(STREAM_TO_MEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_stream_err(ev_stream_err), .ev_eop(ev_eop),
  .ev_desc_done(ev_desc_done), .ctl_run(ctl_run), .eng_idle(eng_idle),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .flags(flag_q), .busy(busy_q)
);

// File: tb/dma_stat_tracker_tb.sv
`timescale 1ns/1ps
module dma_stat_tracker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_stream_err = 0, ev_eop = 0, ev_desc_done = 0, ev_chain_done = 0;
  logic ctl_run = 0, ctl_stop_on_err = 0, eng_idle = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata_m2m;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_stat_tracker #(.STREAM_TO_MEM(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_stream_err(ev_stream_err), .ev_eop(ev_eop),
    .ev_desc_done(ev_desc_done), .ev_chain_done(ev_chain_done), .ctl_run(ctl_run),
    .ctl_stop_on_err(ctl_stop_on_err), .eng_idle(eng_idle), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  dma_stat_tracker #(.STREAM_TO_MEM(1'b0)) u_dut_m2m (
    .clk(clk), .rst_n(rst_n), .ev_stream_err(ev_stream_err), .ev_eop(ev_eop),
    .ev_desc_done(ev_desc_done), .ev_chain_done(ev_chain_done), .ctl_run(ctl_run),
    .ctl_stop_on_err(ctl_stop_on_err), .eng_idle(eng_idle), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(rdata_m2m));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start just after a falling edge
  task automatic do_read(output logic [31:0] v);
    reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic do_write(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    do_write(32'h0000_000F);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_read(v);
    chk("R11 reset", v, 32'h0);
  endtask

  task automatic t_error_flag();
    logic [31:0] v;
    ev_stream_err = 1; @(negedge clk); ev_stream_err = 0;
    do_read(v); chk("R1 set", v, 32'h1);
    do_write(32'h0); do_read(v); chk("R10 write0 keeps", v, 32'h1);
    do_write(32'h1); do_read(v); chk("R1 clear", v, 32'h0);
  endtask

  task automatic t_eop_flag();
    logic [31:0] v;
    ev_eop = 1; @(negedge clk); ev_eop = 0;
    do_read(v); chk("R2 set", v, 32'h2);
    chk("R3 m2m stays 0", rdata_m2m, 32'h0);
    do_write(32'h2); do_read(v); chk("R2 clear", v, 32'h0);
  endtask

  task automatic t_desc_chain();
    logic [31:0] v;
    ev_desc_done = 1; @(negedge clk); ev_desc_done = 0;
    repeat (3) @(negedge clk);
    do_read(v); chk("R4 sticky", v, 32'h4);
    ev_chain_done = 1; @(negedge clk); ev_chain_done = 0;
    do_read(v); chk("R5 set", v, 32'hC);
    do_write(32'h8); do_read(v); chk("R5 clear only chain", v, 32'h4);
    do_write(32'h4); do_read(v); chk("R4 clear", v, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    ev_desc_done = 1; reg_wr = 1; reg_wdata = 32'h4;
    @(negedge clk);
    ev_desc_done = 0; reg_wr = 0; reg_wdata = '0;
    do_read(v); chk("R10 set wins", v, 32'h4);
    clear_all();
  endtask

  task automatic t_busy_run();
    logic [31:0] v;
    eng_idle = 0;
    ctl_run = 1; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    chk("R6 not yet busy", reg_rdata, 32'h0);
    do_read(v); chk("R6 busy after one cycle", v, 32'h10);
    do_write(32'hFFFF_FFFF); do_read(v); chk("R6/R9 write ignored", v, 32'h10);
    ctl_run = 0;
    repeat (2) @(negedge clk);
    do_read(v); chk("R7 busy while not idle", v, 32'h10);
    eng_idle = 1; @(negedge clk);
    do_read(v); chk("R7 busy falls", v, 32'h0);
  endtask

  task automatic t_busy_errstop();
    logic [31:0] v;
    eng_idle = 0; ctl_stop_on_err = 1;
    ctl_run = 1; @(negedge clk);
    ev_stream_err = 1; @(negedge clk); ev_stream_err = 0;
    repeat (2) @(negedge clk);
    do_read(v); chk("R8 busy until desc done", v, 32'h11);
    ev_desc_done = 1; @(negedge clk); ev_desc_done = 0;
    do_read(v); chk("R8 busy falls on desc done", v, 32'h5);
    ctl_run = 0; ctl_stop_on_err = 0; eng_idle = 1;
    @(negedge clk);
    clear_all();
    do_read(v); chk("R8 cleanup", v, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    ev_chain_done = 1; @(negedge clk); ev_chain_done = 0;
    repeat (3) @(negedge clk);
    chk("R11 rdata held", reg_rdata, 32'h0);
    do_read(v); chk("R11 new read", v, 32'h8);
    do_write(32'hFFFF_FFF0); do_read(v); chk("R9 reserved write", v, 32'h8);
    clear_all();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_error_flag();
    t_eop_flag();
    t_desc_chain();
    t_set_wins();
    t_busy_run();
    t_busy_errstop();
    t_hold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule